// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular receive area of packet RAM. The area is a run of 256-byte pages. The host configures it with a first page and an end page, and the end page is exclusive. Bytes arrive on a simple stream with a frame-open strobe, a byte strobe, a frame-close strobe and a CRC-good flag. Each byte is written straight to RAM through a byte-wide write port. The first byte of a frame lands four bytes into the page named by the write-page pointer.

When a good frame closes, the block writes a four-byte header in front of the data. The header holds a status byte, the page where the next frame will start, and the byte count. The byte count includes the four FCS bytes. After the header, the write-page pointer moves on to that next page.

The host owns a trailing page pointer. To free a frame, the host sets this pointer to one page before the frame's next-page link. A frame that would write into the trailing page, or finish on it, is abandoned and raises a sticky overflow flag. The host clears the flag by writing 1 to it.

Top module: `rxring_mgr`

## Requirements
- R1: After reset, the write page and the trailing page are 0, the overflow flag is 0, and no RAM write occurs.
- R2: Byte i of a frame (i counted from 0) is written at RAM address {page, offset}. Counting from the point that is 4 bytes into the write page held when the frame opens, each byte moves one offset forward. An address is page*256 + offset.
- R3: Stepping past page end-1 goes to the first page. This applies to the data address and to the computed next page. The end page is never used.
- R4: A good frame's header is written during the 4 cycles that follow the close strobe, at offsets 0 to 3 of the frame's first page. Offset 0 holds status 0x01 (bit 0 = frame intact). Offset 1 holds the next page. Offset 2 holds count[7:0] and offset 3 holds count[15:8]. The count is the number of bytes received.
- R5: When the header is complete, the write page becomes the next page. The next page is the page after the last data byte. A frame that exactly fills its last page gets the page right after it.
- R6: A frame closed with the CRC-good flag low writes no header and leaves the write page unchanged.
- R7: If a byte would be written into the trailing page, the overflow flag is set, the byte and the rest of the frame are not written, and the write page is unchanged.
- R8: If a good frame's next page equals the trailing page, the overflow flag is set at close, no header is written, and the write page is unchanged.
- R9: The overflow flag stays set until a clear pulse. On a cycle where a new overflow occurs, setting wins over clearing.
- R10: The empty output is 1 exactly when the write page equals the trailing page plus one, wrapped per R3.
- R11: Byte and close strobes outside an open frame cause no RAM writes.
- R12: Host writes to the write page or the trailing page take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pageStart | input | 8 | First page of the ring |
| pageStop | input | 8 | Exclusive end page of the ring |
| curWe | input | 1 | Host write strobe for the write page |
| curData | input | 8 | Host value for the write page |
| bndWe | input | 1 | Host write strobe for the trailing page |
| bndData | input | 8 | Host value for the trailing page |
| ovwClr | input | 1 | Clear pulse for the overflow flag |
| rxStart | input | 1 | Frame open strobe |
| rxValid | input | 1 | Byte strobe |
| rxData | input | 8 | Frame byte |
| rxEnd | input | 1 | Frame close strobe |
| rxGood | input | 1 | CRC-good flag, sampled with rxEnd |
| memWe | output | 1 | RAM write enable |
| memAddr | output | 16 | RAM byte address |
| memData | output | 8 | RAM write data |
| curPage | output | 8 | Write page |
| bndPage | output | 8 | Trailing page |
| ovwFlag | output | 1 | Sticky overflow flag |
| ringEmpty | output | 1 | Ring holds no unread frame |

## Verification
The hardest case to reach is the close-time overflow. In that case the last byte exactly fills the page just before the trailing page, so no byte ever touches the trailing page. Only the computed next page collides with it.

The bench reaches this case by having the host move the trailing page to a chosen page. It then sends a frame whose length plus 4 is a whole multiple of 256.

Wrapping, mid-frame overflow and the next-page wrap are reached the same way. The bench sets the write page and the trailing page through the host strobes so that a frame straddles the end page.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int HDR_BYTES = 4;
  localparam logic [7:0] STAT_INTACT = 8'h01;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DROP, ST_HDR} rxState_t;

  typedef struct packed {
    logic       capStart;
    logic       dataWr;
    logic       hdrWr;
    logic [1:0] hdrIdx;
    logic       commit;
    logic       setOvw;
  } ringStrobe_t;
endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxStart,
  input  logic        rxValid,
  input  logic        rxEnd,
  input  logic        rxGood,
  input  logic        wrHitsBnd,
  input  logic        endHitsBnd,
  output ringStrobe_t strb
);
  rxState_t stQ, stNext;
  logic [1:0] idxQ;

  always_comb begin
    strb   = '0;
    stNext = stQ;
    unique case (stQ)
      ST_IDLE: if (rxStart) begin
        strb.capStart = 1'b1;
        stNext        = ST_RECV;
      end
      ST_RECV: begin
        if (rxEnd) begin
          if (!rxGood) stNext = ST_IDLE;
          else if (endHitsBnd) begin
            strb.setOvw = 1'b1;
            stNext      = ST_IDLE;
          end else stNext = ST_HDR;
        end else if (rxValid) begin
          if (wrHitsBnd) begin
            strb.setOvw = 1'b1;
            stNext      = ST_DROP;
          end else strb.dataWr = 1'b1;
        end
      end
      ST_DROP: if (rxEnd) stNext = ST_IDLE;
      ST_HDR: begin
        strb.hdrWr  = 1'b1;
        strb.hdrIdx = idxQ;
        if (idxQ == 2'(HDR_BYTES - 1)) begin
          strb.commit = 1'b1;
          stNext      = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ  <= ST_IDLE;
      idxQ <= '0;
    end else begin
      stQ  <= stNext;
      idxQ <= (stQ == ST_HDR) ? idxQ + 2'd1 : 2'd0;
    end
  end

  // R2: a cycle carries at most one RAM write source
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.dataWr, strb.hdrWr, strb.capStart}))
    else $error("two write sources in one cycle");

  // R5: header completion returns the control to idle
  assert_commit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> (stQ == ST_IDLE))
    else $error("control not idle after commit");
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAGE_W-1:0]     pageStart,
  input  logic [PAGE_W-1:0]     pageStop,
  input  logic                  curWe,
  input  logic [PAGE_W-1:0]     curData,
  input  logic                  bndWe,
  input  logic [PAGE_W-1:0]     bndData,
  input  logic                  ovwClr,
  input  logic [7:0]            rxData,
  input  ringStrobe_t           st,
  output logic                  wrHitsBnd,
  output logic                  endHitsBnd,
  output logic                  memWe,
  output logic [PAGE_W+7:0]     memAddr,
  output logic [7:0]            memData,
  output logic [PAGE_W-1:0]     curPage,
  output logic [PAGE_W-1:0]     bndPage,
  output logic                  ovwFlag,
  output logic                  ringEmpty
);
  localparam int OFF_W = 8;
  localparam int LEN_W = 16;

  logic [PAGE_W-1:0] frmPage, wrPage, endNext, bndNext;
  logic [OFF_W-1:0]  wrOff;
  logic [LEN_W-1:0]  byteCnt;
  logic [7:0]        hdrByte;

  function automatic logic [PAGE_W-1:0] stepPage(input logic [PAGE_W-1:0] p,
      input logic [PAGE_W-1:0] first, input logic [PAGE_W-1:0] last);
    logic [PAGE_W-1:0] q;
    q = p + 1'b1;
    return (q == last) ? first : q;
  endfunction

  assign endNext    = (wrOff == '0) ? wrPage : stepPage(wrPage, pageStart, pageStop);
  assign bndNext    = stepPage(bndPage, pageStart, pageStop);
  assign wrHitsBnd  = (wrPage == bndPage);
  assign endHitsBnd = (endNext == bndPage);
  assign ringEmpty  = (curPage == bndNext);

  always_comb begin
    unique case (st.hdrIdx)
      2'd0:    hdrByte = STAT_INTACT;
      2'd1:    hdrByte = 8'(endNext);
      2'd2:    hdrByte = byteCnt[7:0];
      default: hdrByte = byteCnt[15:8];
    endcase
  end

  assign memWe   = st.dataWr | st.hdrWr;
  assign memAddr = st.hdrWr ? {frmPage, (OFF_W-2)'(0), st.hdrIdx} : {wrPage, wrOff};
  assign memData = st.hdrWr ? hdrByte : rxData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frmPage <= '0;
      wrPage  <= '0;
      wrOff   <= '0;
      byteCnt <= '0;
    end else if (st.capStart) begin
      frmPage <= curPage;
      wrPage  <= curPage;
      wrOff   <= OFF_W'(HDR_BYTES);
      byteCnt <= '0;
    end else if (st.dataWr) begin
      wrOff   <= wrOff + 1'b1;
      byteCnt <= byteCnt + 1'b1;
      if (&wrOff) wrPage <= stepPage(wrPage, pageStart, pageStop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPage <= '0;
      bndPage <= '0;
      ovwFlag <= 1'b0;
    end else begin
      if (st.commit)  curPage <= endNext;
      else if (curWe) curPage <= curData;
      if (bndWe) bndPage <= bndData;
      if (st.setOvw)   ovwFlag <= 1'b1;
      else if (ovwClr) ovwFlag <= 1'b0;
    end
  end

  // R6: the write page moves only on commit or host write
  assert_cur_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.commit && !curWe) |=> $stable(curPage))
    else $error("write page moved without cause");

  // R7: no data byte lands in the trailing page
  assert_no_write_bnd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st.dataWr |-> (memAddr[PAGE_W+7:OFF_W] != bndPage))
    else $error("data written into trailing page");

  assert_ovw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st.setOvw |=> ovwFlag)
    else $error("overflow not flagged");

  assert_ovw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovwClr && !st.setOvw) |=> !ovwFlag)
    else $error("overflow flag not cleared");

  // R3: a committed page stays inside the ring (valid configuration)
  assert_cur_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st.commit && frmPage >= pageStart && frmPage < pageStop)
      |=> (curPage >= pageStart && curPage < pageStop))
    else $error("write page left the ring");
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] pageStart,
  input  logic [PAGE_W-1:0] pageStop,
  input  logic              curWe,
  input  logic [PAGE_W-1:0] curData,
  input  logic              bndWe,
  input  logic [PAGE_W-1:0] bndData,
  input  logic              ovwClr,
  input  logic              rxStart,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic              rxGood,
  output logic              memWe,
  output logic [PAGE_W+7:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] curPage,
  output logic [PAGE_W-1:0] bndPage,
  output logic              ovwFlag,
  output logic              ringEmpty
);
  ringStrobe_t strb;
  logic wrHitsBnd, endHitsBnd;

  rxring_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxStart(rxStart), .rxValid(rxValid),
    .rxEnd(rxEnd), .rxGood(rxGood), .wrHitsBnd(wrHitsBnd),
    .endHitsBnd(endHitsBnd), .strb(strb)
  );

  rxring_dp #(.PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .pageStart(pageStart), .pageStop(pageStop),
    .curWe(curWe), .curData(curData), .bndWe(bndWe), .bndData(bndData),
    .ovwClr(ovwClr), .rxData(rxData), .st(strb), .wrHitsBnd(wrHitsBnd),
    .endHitsBnd(endHitsBnd), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .curPage(curPage), .bndPage(bndPage),
    .ovwFlag(ovwFlag), .ringEmpty(ringEmpty)
  );
endmodule

// File: tb/rxring_mgr_tb.sv
`timescale 1ns/1ps
module rxring_mgr_tb;
  localparam int START = 8'h40;
  localparam int STOP  = 8'h46;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] pageStart = 8'(START), pageStop = 8'(STOP);
  logic curWe = 0, bndWe = 0, ovwClr = 0;
  logic [7:0] curData = 0, bndData = 0;
  logic rxStart = 0, rxValid = 0, rxEnd = 0, rxGood = 0;
  logic [7:0] rxData = 0;
  logic memWe, ovwFlag, ringEmpty;
  logic [15:0] memAddr;
  logic [7:0] memData, curPage, bndPage;

  rxring_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .pageStart(pageStart), .pageStop(pageStop),
    .curWe(curWe), .curData(curData), .bndWe(bndWe), .bndData(bndData),
    .ovwClr(ovwClr), .rxStart(rxStart), .rxValid(rxValid), .rxData(rxData),
    .rxEnd(rxEnd), .rxGood(rxGood), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .curPage(curPage), .bndPage(bndPage),
    .ovwFlag(ovwFlag), .ringEmpty(ringEmpty)
  );

  logic [7:0] dutMem [0:65535];
  logic [7:0] expMem [0:65535];
  always @(posedge clk) if (memWe) dutMem[memAddr] <= memData;

  int checks = 0, failures = 0;
  int expCur = 0, expBnd = 0;
  bit expOvw = 0, cmpOn = 0, done = 0;

  function automatic int nxtPg(int p);
    return (p + 1 == STOP) ? START : p + 1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference state compared on every clock (R5/R6 write page, R12 trailing page)
  always @(negedge clk) if (cmpOn) begin
    check(curPage == 8'(expCur), "R5", "curPage", curPage, expCur);
    check(bndPage == 8'(expBnd), "R12", "bndPage", bndPage, expBnd);
    check(ovwFlag == expOvw, "R9", "ovwFlag", ovwFlag, expOvw);
    check(ringEmpty == (expCur == nxtPg(expBnd)), "R10", "ringEmpty",
          ringEmpty, expCur == nxtPg(expBnd));
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hostCur(int v);
    curWe = 1; curData = 8'(v); tick(); curWe = 0; expCur = v;
  endtask

  task automatic hostBnd(int v);
    bndWe = 1; bndData = 8'(v); tick(); bndWe = 0; expBnd = v;
  endtask

  task automatic clrOvw();
    ovwClr = 1; tick(); ovwClr = 0; expOvw = 0;
  endtask

  task automatic memCompare(string req);
    int bad = 0, firstA = -1;
    for (int a = 0; a < 65536; a++)
      if (dutMem[a] !== expMem[a]) begin
        bad++;
        if (firstA < 0) firstA = a;
      end
    check(bad == 0, req, "RAM mismatches (count, first addr in expected)", bad, firstA);
  endtask

  task automatic sendFrame(int n, bit good, int seed, string req);
    int pg = expCur, off = 4, hdrPg = expCur, nxt;
    bit ovf = 0, hit, endHit;
    rxStart = 1; tick(); rxStart = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 7) & 255);
      rxValid = 1; rxData = b; hit = 0;
      if (!ovf) begin
        if (pg == expBnd) begin
          ovf = 1; hit = 1;
        end else begin
          expMem[pg * 256 + off] = b;
          off++;
          if (off == 256) begin off = 0; pg = nxtPg(pg); end
        end
      end
      tick();
      if (hit) expOvw = 1;
    end
    rxValid = 0;
    nxt = (off == 0) ? pg : nxtPg(pg);
    endHit = !ovf && good && (nxt == expBnd);
    rxEnd = 1; rxGood = good; tick(); rxEnd = 0; rxGood = 0;
    if (endHit) expOvw = 1;
    if (good && !ovf && !endHit) begin
      expMem[hdrPg * 256 + 0] = 8'h01;
      expMem[hdrPg * 256 + 1] = 8'(nxt);
      expMem[hdrPg * 256 + 2] = 8'(n & 255);
      expMem[hdrPg * 256 + 3] = 8'((n >> 8) & 255);
      repeat (3) tick();
      tick(); expCur = nxt;
    end
    repeat (2) tick();
    memCompare(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(curPage == 0, "R1", "curPage in reset", curPage, 0);
    check(bndPage == 0, "R1", "bndPage in reset", bndPage, 0);
    check(ovwFlag == 0, "R1", "ovwFlag in reset", ovwFlag, 0);
    check(memWe == 0, "R1", "memWe in reset", memWe, 0);
    @(posedge clk); #1; rst_n = 1; cmpOn = 1;
    tick();
    hostCur(START); hostBnd(STOP - 1);           // R12, R10 empty
    sendFrame(60, 1, 3, "R2");                    // R4 header, R5
    sendFrame(252, 1, 9, "R5");                   // exact page fill
    hostBnd(8'h40);
    sendFrame(100, 0, 17, "R6");                  // bad CRC
    sendFrame(600, 1, 21, "R4");                  // multi-page
    sendFrame(300, 1, 33, "R7");                  // mid-frame overflow
    clrOvw();
    hostBnd(8'h44);
    sendFrame(300, 1, 41, "R3");                  // data wraps to first page
    sendFrame(764, 1, 55, "R8");                  // close-time overflow
    ovwClr = 1; tick(); ovwClr = 0; expOvw = 0;   // R9 clear
    // R11: strobes outside a frame
    rxValid = 1; rxData = 8'hA5; repeat (3) tick();
    rxValid = 0; rxEnd = 1; rxGood = 1; tick(); rxEnd = 0; rxGood = 0;
    repeat (2) tick();
    memCompare("R11");
    hostBnd(8'h40);                               // R10 empty again
    sendFrame(0, 1, 0, "R4");                     // zero-length frame
    hostCur(8'h45); hostBnd(8'h44);
    sendFrame(100, 1, 77, "R3");                  // next page wraps
    hostBnd(STOP - 1);                            // R10 empty after wrap release
    repeat (3) tick();
    cmpOn = 0; done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule